// File: doc/BRIEF.md
# Boot-Store and SRAM Memory Controller

This controller sits between a small 16-bit processor and two memories. An on-chip read-only boot store of 256 sixteen-bit words answers at the bottom of the address space. External asynchronous SRAM covers the rest. Every request is steered by its address. The controller drives the SRAM address, data and strobes, and it raises a ready handshake to the processor when the access is complete.

Accesses to the boot store complete in the cycle they are presented. Every SRAM access carries one wait state. The SRAM word has no per-byte write strobes, so a byte store reads the whole word, replaces one byte, and writes the word back. The other byte is preserved. Everything is clocked on one rising edge, with an active-high synchronous reset.

Top module: `memctl_top`

## Requirements
- R1: A read from the boot store raises `cpu_rdy` in the same cycle as `cpu_req`. The returned word at word index i (i = `cpu_addr[8:1]`) is {i XOR 8'hA5, i}.
- R2: Byte addresses with bits [15:9] all zero select the boot store. Every other address selects SRAM. `sram_addr` carries `cpu_addr[15:1]`.
- R3: An SRAM word read raises `cpu_rdy` in the second cycle after the request cycle and returns the addressed SRAM word. During it, `sram_oe_n` is low, `sram_we_n` is high and `sram_dq_oe` is low.
- R4: An SRAM word write strobes `sram_we_n` low in the first cycle after the request, with `sram_dq_o` equal to `cpu_wdata`. It raises `cpu_rdy` in the second cycle after the request.
- R5: For byte operations (`cpu_byte`=1), `cpu_addr[0]`=0 selects bits [7:0] and 1 selects bits [15:8]. A byte load returns the selected byte zero-extended, from either memory.
- R6: An SRAM byte store runs read, wait, write, wait and raises `cpu_rdy` in the fourth cycle after the request. The new byte is `cpu_wdata[7:0]`, placed in the selected lane, and the other byte of the word keeps its old value.
- R7: A write to the boot store has no effect on the stored content and drives no SRAM strobe. It still raises `cpu_rdy` in the same cycle.
- R8: `sram_oe_n` and `sram_we_n` are never low together. `sram_dq_oe` is never high while `sram_oe_n` is low.
- R9: While reset is applied and with no request, `cpu_rdy` is low, the SRAM strobes are high and `sram_dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request, held until `cpu_rdy` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_byte | input | 1 | 1 = byte access, 0 = word access |
| cpu_addr | input | 16 | Byte address |
| cpu_wdata | input | 16 | Store data (the low byte is used for byte stores) |
| cpu_rdata | output | 16 | Load data, valid with `cpu_rdy` |
| cpu_rdy | output | 1 | Access complete |
| sram_addr | output | 15 | SRAM word address |
| sram_dq_o | output | 16 | Data driven toward the SRAM |
| sram_dq_oe | output | 1 | Drive enable for `sram_dq_o` |
| sram_dq_i | input | 16 | Data returned by the SRAM |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |

## Verification
Ready is due in one of three cycles after the request is driven:
- in the same cycle for the boot store,
- two cycles later for SRAM word accesses and byte loads,
- four cycles later for SRAM byte stores.

Each stimulus vector carries its expected latency. The bench counts whole clock cycles from the request to the first sampled `cpu_rdy`, and compares that count with the vector's value. Load data is compared in that same ready cycle.

Stored values are confirmed by later reads against a bench model of the SRAM. Strobe exclusivity is watched on every cycle.

// File: rtl/memctl_pkg.sv
package memctl_pkg;
    localparam int DATA_W = 16;
    localparam int LANE_W = DATA_W / 2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_RD_WAIT,
        ST_WR_ACC,
        ST_WR_WAIT,
        ST_RMW_RD,
        ST_RMW_RWAIT,
        ST_RMW_WR,
        ST_RMW_WWAIT
    } sram_state_e;

    // Lane pick with zero extension
    function automatic logic [DATA_W-1:0] lane_pick(input logic [DATA_W-1:0] w,
                                                    input logic hi);
        return hi ? {{LANE_W{1'b0}}, w[DATA_W-1:LANE_W]}
                  : {{LANE_W{1'b0}}, w[LANE_W-1:0]};
    endfunction

    // Replace one lane of a word, keep the other
    function automatic logic [DATA_W-1:0] lane_merge(input logic [DATA_W-1:0] old_w,
                                                     input logic [LANE_W-1:0] nb,
                                                     input logic hi);
        return hi ? {nb, old_w[LANE_W-1:0]} : {old_w[DATA_W-1:LANE_W], nb};
    endfunction
endpackage

// File: rtl/memctl_bootrom.sv
module memctl_bootrom #(
    parameter int IDX_W = 8
) (
    input  logic [IDX_W-1:0]                idx,
    output logic [memctl_pkg::DATA_W-1:0]   word
);
    localparam int HI_W = memctl_pkg::DATA_W - IDX_W;
    // Contents are computed: upper part is index XOR a fixed pattern
    localparam logic [HI_W-1:0] PATTERN = HI_W'(8'hA5);

    always_comb begin
        word = {PATTERN ^ HI_W'(idx), idx};
    end
endmodule

// File: rtl/memctl_sram_fsm.sv
module memctl_sram_fsm
    import memctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              is_wr,
    input  logic              is_byte,
    input  logic              lane_hi,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] dq_i,
    output logic              done,
    output logic              ce_n,
    output logic              oe_n,
    output logic              we_n,
    output logic              dq_oe,
    output logic [DATA_W-1:0] dq_o
);
    sram_state_e state, state_nx;
    logic [DATA_W-1:0] hold_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:
                if (start) begin
                    if (is_wr && is_byte) state_nx = ST_RMW_RD;
                    else if (is_wr)       state_nx = ST_WR_ACC;
                    else                  state_nx = ST_RD_ACC;
                end
            ST_RD_ACC:    state_nx = ST_RD_WAIT;
            ST_RD_WAIT:   state_nx = ST_IDLE;
            ST_WR_ACC:    state_nx = ST_WR_WAIT;
            ST_WR_WAIT:   state_nx = ST_IDLE;
            ST_RMW_RD:    state_nx = ST_RMW_RWAIT;
            ST_RMW_RWAIT: state_nx = ST_RMW_WR;
            ST_RMW_WR:    state_nx = ST_RMW_WWAIT;
            ST_RMW_WWAIT: state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // Capture the old word at the end of the read-wait phase
    always_ff @(posedge clk) begin
        if (rst)                        hold_q <= '0;
        else if (state == ST_RMW_RWAIT) hold_q <= dq_i;
    end

    always_comb begin
        ce_n  = (state == ST_IDLE);
        oe_n  = !(state inside {ST_RD_ACC, ST_RD_WAIT, ST_RMW_RD, ST_RMW_RWAIT});
        we_n  = !(state inside {ST_WR_ACC, ST_RMW_WR});
        dq_oe = state inside {ST_WR_ACC, ST_WR_WAIT, ST_RMW_WR, ST_RMW_WWAIT};
        done  = state inside {ST_RD_WAIT, ST_WR_WAIT, ST_RMW_WWAIT};
        dq_o  = (state inside {ST_RMW_WR, ST_RMW_WWAIT})
                ? lane_merge(hold_q, wdata[LANE_W-1:0], lane_hi) : wdata;
    end
endmodule

// File: rtl/memctl_top.sv
module memctl_top
    import memctl_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int ROM_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              cpu_byte,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_rdy,
    output logic [ADDR_W-2:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_o,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_i,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n
);
    localparam int REGION_LSB = ROM_AW + 1;

    logic              rom_hit;
    logic              sram_done;
    logic [DATA_W-1:0] rom_word;
    logic [DATA_W-1:0] src_word;

    assign rom_hit   = (cpu_addr[ADDR_W-1:REGION_LSB] == '0);
    assign sram_addr = cpu_addr[ADDR_W-1:1];

    memctl_bootrom #(.IDX_W(ROM_AW)) u_rom (
        .idx  (cpu_addr[ROM_AW:1]),
        .word (rom_word)
    );

    memctl_sram_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .start   (cpu_req && !rom_hit),
        .is_wr   (cpu_we),
        .is_byte (cpu_byte),
        .lane_hi (cpu_addr[0]),
        .wdata   (cpu_wdata),
        .dq_i    (sram_dq_i),
        .done    (sram_done),
        .ce_n    (sram_ce_n),
        .oe_n    (sram_oe_n),
        .we_n    (sram_we_n),
        .dq_oe   (sram_dq_oe),
        .dq_o    (sram_dq_o)
    );

    always_comb begin
        src_word  = rom_hit ? rom_word : sram_dq_i;
        cpu_rdata = cpu_byte ? lane_pick(src_word, cpu_addr[0]) : src_word;
        cpu_rdy   = (cpu_req && rom_hit) || sram_done;
    end
endmodule

// File: rtl/memctl_checker.sv
module memctl_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic              cpu_byte,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_rdy,
    input logic              sram_ce_n,
    input logic              sram_oe_n,
    input logic              sram_we_n,
    input logic              sram_dq_oe
);
    logic       boot;
    logic [3:0] wait_cnt;

    assign boot = (cpu_addr[ADDR_W-1:9] == '0);

    always_ff @(posedge clk) begin
        if (rst || !cpu_req || cpu_rdy) wait_cnt <= '0;
        else if (wait_cnt != 4'hF)      wait_cnt <= wait_cnt + 4'd1;
    end

    p_boot_same_cycle_r1: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && boot) |-> cpu_rdy);
    p_boot_wr_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && boot && cpu_we) |-> (sram_we_n && sram_ce_n));
    p_word_latency_r3: assert property (@(posedge clk) disable iff (rst)
        (cpu_rdy && !boot && !(cpu_we && cpu_byte)) |-> (wait_cnt == 4'd2));
    p_rmw_latency_r6: assert property (@(posedge clk) disable iff (rst)
        (cpu_rdy && !boot && cpu_we && cpu_byte) |-> (wait_cnt == 4'd4));
    p_strobe_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(!sram_oe_n && !sram_we_n));
    p_no_contention_r8: assert property (@(posedge clk) disable iff (rst)
        sram_dq_oe |-> sram_oe_n);
    p_write_bus_r4: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> sram_dq_oe);
endmodule

bind memctl_top memctl_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_byte   (cpu_byte),
    .cpu_addr   (cpu_addr),
    .cpu_rdy    (cpu_rdy),
    .sram_ce_n  (sram_ce_n),
    .sram_oe_n  (sram_oe_n),
    .sram_we_n  (sram_we_n),
    .sram_dq_oe (sram_dq_oe)
);

// File: tb/memctl_top_bench.sv
module memctl_top_bench;
    typedef struct packed {
        logic        we;
        logic        bt;
        logic [15:0] addr;
        logic [15:0] wd;
        logic        chk;
        logic [15:0] exp;
        logic [3:0]  lat;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VT [NV] = '{
        '{1'b0, 1'b0, 16'h0200, 16'h0000, 1'b1, 16'h00FF, 4'd2, 4'd2}, // R2 first SRAM word
        '{1'b0, 1'b0, 16'h01FE, 16'h0000, 1'b1, 16'h5AFF, 4'd0, 4'd2}, // R2 last boot word
        '{1'b1, 1'b0, 16'h1010, 16'h1234, 1'b0, 16'h0000, 4'd2, 4'd4}, // R4
        '{1'b0, 1'b0, 16'h1010, 16'h0000, 1'b1, 16'h1234, 4'd2, 4'd3}, // R3
        '{1'b1, 1'b1, 16'h1011, 16'h00AB, 1'b0, 16'h0000, 4'd4, 4'd6}, // R6 high lane
        '{1'b0, 1'b0, 16'h1010, 16'h0000, 1'b1, 16'hAB34, 4'd2, 4'd6}, // R6
        '{1'b0, 1'b1, 16'h1010, 16'h0000, 1'b1, 16'h0034, 4'd2, 4'd5}, // R5
        '{1'b0, 1'b1, 16'h1011, 16'h0000, 1'b1, 16'h00AB, 4'd2, 4'd5}, // R5
        '{1'b1, 1'b1, 16'h1010, 16'hFF5C, 1'b0, 16'h0000, 4'd4, 4'd6}, // R6 low lane
        '{1'b0, 1'b0, 16'h1010, 16'h0000, 1'b1, 16'hAB5C, 4'd2, 4'd6}, // R6
        '{1'b1, 1'b0, 16'h1012, 16'hBEEF, 1'b0, 16'h0000, 4'd2, 4'd4}, // R4
        '{1'b0, 1'b0, 16'h1012, 16'h0000, 1'b1, 16'hBEEF, 4'd2, 4'd3}, // R3
        '{1'b0, 1'b0, 16'h1010, 16'h0000, 1'b1, 16'hAB5C, 4'd2, 4'd6}, // R6 neighbour intact
        '{1'b0, 1'b0, 16'h0006, 16'h0000, 1'b1, 16'hA603, 4'd0, 4'd1}, // R1
        '{1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1, 16'hA500, 4'd0, 4'd1}, // R1
        '{1'b0, 1'b1, 16'h01FF, 16'h0000, 1'b1, 16'h005A, 4'd0, 4'd5}, // R5 boot byte
        '{1'b0, 1'b1, 16'h0006, 16'h0000, 1'b1, 16'h0003, 4'd0, 4'd5}, // R5
        '{1'b1, 1'b0, 16'h0006, 16'hFFFF, 1'b0, 16'h0000, 4'd0, 4'd7}, // R7
        '{1'b1, 1'b1, 16'h0007, 16'h0011, 1'b0, 16'h0000, 4'd0, 4'd7}, // R7
        '{1'b0, 1'b0, 16'h0006, 16'h0000, 1'b1, 16'hA603, 4'd0, 4'd7}  // R7 readback
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_byte = 1'b0;
    logic [15:0] cpu_addr = '0, cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        cpu_rdy;
    logic [14:0] sram_addr;
    logic [15:0] sram_dq_o, sram_dq_i;
    logic        sram_dq_oe, sram_ce_n, sram_oe_n, sram_we_n;

    int checks = 0;
    int fails = 0;
    int bus_bad = 0;
    int strobe_bad = 0;
    logic [15:0] mem [256];

    always #2.5 clk = ~clk;

    memctl_top u_memctl_top (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_byte(cpu_byte), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_rdy(cpu_rdy), .sram_addr(sram_addr),
        .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i),
        .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n)
    );

    // SRAM model
    initial for (int i = 0; i < 256; i++) mem[i] = {8'(i), ~8'(i)};
    always_comb sram_dq_i = (!sram_ce_n && !sram_oe_n) ? mem[sram_addr[7:0]] : 16'h0000;
    always @(posedge clk) if (!sram_ce_n && !sram_we_n) mem[sram_addr[7:0]] <= sram_dq_o;

    // Per-cycle strobe monitor (R8) and write-bus monitor (R4)
    always @(negedge clk) begin
        if (!rst) begin
            if (!sram_oe_n && !sram_we_n) strobe_bad++;
            if (sram_dq_oe && !sram_oe_n) strobe_bad++;
            if (!sram_we_n && !sram_dq_oe) bus_bad++;
        end
    end

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic run_op(input vec_t v);
        int lat;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = v.we; cpu_byte = v.bt;
        cpu_addr = v.addr; cpu_wdata = v.wd;
        lat = 0;
        forever begin
            #1;
            if (cpu_rdy || lat > 12) break;
            @(negedge clk);
            lat++;
        end
        check($sformatf("R%0d latency @%0h", v.rq, v.addr), 32'(lat), 32'(v.lat));
        if (v.chk) check($sformatf("R%0d data @%0h", v.rq, v.addr), 32'(cpu_rdata), 32'(v.exp));
        if (v.addr[15:9] == 7'd0 && v.we)
            check("R7 no SRAM strobe", {31'd0, sram_ce_n & sram_we_n}, 32'd1);
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                #1;
                check("R9 rdy low", {31'd0, cpu_rdy}, 32'd0);
                check("R9 strobes high", {29'd0, sram_ce_n, sram_oe_n, sram_we_n}, 32'd7);
                check("R9 bus idle", {31'd0, sram_dq_oe}, 32'd0);
                @(negedge clk);
                rst = 1'b0;
                for (int k = 0; k < NV; k++) run_op(VT[k]);
                // Directed: word write phase shows data on the bus (R4)
                @(negedge clk);
                cpu_req = 1'b1; cpu_we = 1'b1; cpu_byte = 1'b0;
                cpu_addr = 16'h2020; cpu_wdata = 16'h5AA5;
                @(negedge clk); #1;
                check("R4 strobe in first cycle", {31'd0, sram_we_n}, 32'd0);
                check("R4 bus data", 32'(sram_dq_o), 32'h5AA5);
                check("R2 word address", 32'(sram_addr), 32'h1010);
                @(negedge clk); #1;
                check("R4 rdy second cycle", {31'd0, cpu_rdy}, 32'd1);
                @(negedge clk);
                cpu_req = 1'b0;
                // Directed: read phase strobes (R3)
                cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 16'h2020;
                @(negedge clk); #1;
                check("R3 read strobes", {29'd0, sram_oe_n, sram_we_n, sram_dq_oe}, 32'b010);
                @(negedge clk); #1;
                check("R3 read data", 32'(cpu_rdata), 32'h5AA5);
                @(negedge clk);
                cpu_req = 1'b0;
                repeat (2) @(negedge clk);
                check("R8 strobe overlap cycles", 32'(strobe_bad), 32'd0);
                check("R4 strobe without bus", 32'(bus_bad), 32'd0);
            end
            begin
                repeat (5000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule